// File: doc/BRIEF.md
# Motion Delta Accumulator with Report Flag

This block gathers per-frame X and Y displacement samples into two signed 8-bit report registers and keeps a motion-pending flag. A host polls these registers over a simple register port. Each frame sample arrives on a valid/ready stream. The sample values are scaled to the 1000 counts-per-inch step. A control register selects whether each sample is added as it comes or halved first. The same control register can also freeze accumulation for power-down.

The host reads the status byte first. If the flag is set, it reads the two delta registers. Reading a delta register returns its value and empties that register only. Writing any value to the status register empties both deltas and the flag at once, and the written byte is discarded. A sample that lands in the same cycle as a clearing access is added after the clear, so no motion is lost. The flag drops by itself once both deltas have been read back to zero with no new motion in between.

The sample stream never applies back-pressure. `smp_ready` is always high, and a sample counts as taken in every cycle where `smp_valid` is high. While power-down is set, samples are still taken but are thrown away.

Top module: `motion_accum`

## Requirements
- R1: After reset the status, delta X, delta Y and control registers all read 0x00.
- R2: Register reads are combinational in the cycle `reg_rd` is high. The status is at address 0x02, with bit 7 holding the motion flag and bits 6..0 reading zero. Delta X is at 0x03, delta Y is at 0x04 and control is at 0x0D. Any other address reads 0x00.
- R3: With control bit 0 set to 1, each sample is added unchanged. With bit 0 set to 0, each sample is first shifted right by one position arithmetically, so -3 becomes -2 and -1 stays -1.
- R4: Each delta saturates at +127 (0x7F) and -128 (0x80) and never wraps.
- R5: An accepted sample whose scaled value on either axis is nonzero sets the motion flag from the next cycle.
- R6: Reading address 0x03 or 0x04 returns the register's current value and clears that delta only.
- R7: A write of any data to 0x02 clears the flag and both deltas. The data byte is not stored.
- R8: A sample accepted in the same cycle as a clearing read or a status write is added to the cleared value.
- R9: A delta read after which both deltas are zero clears the flag, unless a nonzero sample was accepted in that same cycle.
- R10: While control bit 1 is 1, accepted samples change neither the deltas nor the flag.
- R11: `smp_ready` is always 1, so every valid sample is consumed in the cycle it is offered.
- R12: Control bits 1..0 are writable and read back. Control bits 7..2 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Frame sample valid |
| smp_ready | output | 1 | Sample accepted (always 1) |
| smp_dx | input | 8 | X displacement, two's complement, 1000 cpi scale |
| smp_dy | input | 8 | Y displacement, two's complement, 1000 cpi scale |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |

## Verification
The assertions check the following on every cycle:
- each delta moves only in the direction of the incoming sample's sign, so it cannot wrap;
- a clearing access with no sample leaves the delta at zero;
- a nonzero sample always raises the flag;
- a status write with no sample drops the flag;
- the deltas hold still under power-down;
- the status byte's low bits are zero.

Only the bench's scenarios can show the rest:
- the exact scaled sums at both resolutions;
- the saturated end values;
- which register a read empties;
- the flag staying up when motion arrives between the two delta reads;
- the old value being returned when a read and a sample share a cycle.

// File: rtl/motion_pkg.sv
package motion_pkg;
  localparam int DW = 8;
  localparam int AW = 7;
  localparam int NAXES = 2;

  localparam logic [AW-1:0] ADDR_STAT = 7'h02;
  localparam logic [AW-1:0] ADDR_DX   = 7'h03;
  localparam logic [AW-1:0] ADDR_DY   = 7'h04;
  localparam logic [AW-1:0] ADDR_CTRL = 7'h0D;

  typedef struct packed {
    logic pd;     // bit 1: freeze accumulation
    logic hires;  // bit 0: 1 = full step, 0 = half step
  } ctrl_t;
endpackage

// File: rtl/motion_axis.sv
module motion_axis #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add_en,
  input  logic         half,
  input  logic [W-1:0] sample,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_d,
  output logic         moved
);
  localparam int SW = W + 1;

  logic signed [W-1:0]  scaled;
  logic signed [W-1:0]  eff;
  logic signed [W-1:0]  base;
  logic signed [SW-1:0] sum;

  always_comb begin
    scaled = half ? ($signed(sample) >>> 1) : $signed(sample);
    eff    = add_en ? scaled : '0;
    base   = clr ? '0 : $signed(acc_q);
    sum    = {base[W-1], base} + {eff[W-1], eff};
    if (sum[SW-1] != sum[SW-2])
      acc_d = sum[SW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      acc_d = sum[W-1:0];
    moved = add_en && (scaled != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  a_r4_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && !clr && !sample[W-1] |=> $signed(acc_q) >= $signed($past(acc_q)));
  a_r4_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && !clr && sample[W-1] |=> $signed(acc_q) <= $signed($past(acc_q)));
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !add_en |=> acc_q == '0);
endmodule

// File: rtl/motion_flag.sv
module motion_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_clr,
  input  logic rd_clr,
  input  logic moved,
  input  logic both_zero,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag <= 1'b0;
    else if (wr_clr)             flag <= moved;
    else if (moved)              flag <= 1'b1;
    else if (rd_clr && both_zero) flag <= 1'b0;
  end

  a_r5_motion_sets: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> flag);
  a_r7_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !moved |=> !flag);
endmodule

// File: rtl/motion_accum.sv
module motion_accum
  import motion_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_dx,
  input  logic [DW-1:0] smp_dy,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  ctrl_t                       ctrl_q;
  logic                        add_en;
  logic                        wr_stat;
  logic [NAXES-1:0]            rd_axis;
  logic [NAXES-1:0]            moved;
  logic [NAXES-1:0][DW-1:0]    acc_q;
  logic [NAXES-1:0][DW-1:0]    acc_d;
  logic                        flag;

  assign smp_ready = 1'b1;
  assign add_en    = smp_valid && !ctrl_q.pd;
  assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
  assign rd_axis[0] = reg_rd && (reg_addr == ADDR_DX);
  assign rd_axis[1] = reg_rd && (reg_addr == ADDR_DY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADDR_CTRL)
      ctrl_q <= ctrl_t'(reg_wdata[1:0]);
  end

  for (genvar g = 0; g < NAXES; g++) begin : g_axis
    logic [DW-1:0] smp;
    assign smp = (g == 0) ? smp_dx : smp_dy;
    motion_axis #(.W(DW)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rd_axis[g] | wr_stat),
      .add_en (add_en),
      .half   (!ctrl_q.hires),
      .sample (smp),
      .acc_q  (acc_q[g]),
      .acc_d  (acc_d[g]),
      .moved  (moved[g])
    );
  end

  motion_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_clr    (wr_stat),
    .rd_clr    (|rd_axis),
    .moved     (|moved),
    .both_zero ((acc_d[0] == '0) && (acc_d[1] == '0)),
    .flag      (flag)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        ADDR_STAT: reg_rdata = {flag, {(DW-1){1'b0}}};
        ADDR_DX:   reg_rdata = acc_q[0];
        ADDR_DY:   reg_rdata = acc_q[1];
        ADDR_CTRL: reg_rdata = {{(DW-2){1'b0}}, ctrl_q};
        default:   reg_rdata = '0;
      endcase
    end
  end

  a_r2_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == ADDR_STAT |-> reg_rdata[DW-2:0] == '0);
  a_r10_powerdown_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.pd && !reg_rd && !reg_wr |=> $stable(acc_q) && $stable(flag));
endmodule

// File: tb/motion_accum_tb.sv
module motion_accum_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [7:0] smp_dx = '0, smp_dy = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] rd_val;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  motion_accum u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_dx(smp_dx), .smp_dy(smp_dy), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // {hires, count[2:0], dx, dy, exp_x, exp_y, exp_flag}
  localparam logic [36:0] VEC [9] = '{
    {1'b1, 3'd1, 8'h0A, 8'hEC, 8'h0A, 8'hEC, 1'b1},
    {1'b0, 3'd1, 8'h0A, 8'hEC, 8'h05, 8'hF6, 1'b1},
    {1'b0, 3'd1, 8'hFD, 8'h07, 8'hFE, 8'h03, 1'b1},
    {1'b1, 3'd2, 8'h64, 8'h9C, 8'h7F, 8'h80, 1'b1},
    {1'b0, 3'd3, 8'h7F, 8'h80, 8'h7F, 8'h80, 1'b1},
    {1'b1, 3'd1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
    {1'b1, 3'd4, 8'h01, 8'hFF, 8'h04, 8'hFC, 1'b1},
    {1'b0, 3'd2, 8'h01, 8'hFF, 8'h00, 8'hFE, 1'b1},
    {1'b0, 3'd1, 8'h01, 8'h01, 8'h00, 8'h00, 1'b0}
  };

  task automatic cyc(input logic rd, input logic wr, input logic [6:0] a,
                     input logic [7:0] wd, input logic v,
                     input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    smp_valid = v; smp_dx = x; smp_dy = y;
    #1 rd_val = reg_rdata;
    @(posedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, input string req, input logic [7:0] exp);
    cyc(1, 0, a, 8'h00, 0, 8'h00, 8'h00);
    chk(req, rd_val, exp);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    cyc(0, 1, a, d, 0, 8'h00, 8'h00);
  endtask

  task automatic smp(input logic [7:0] x, input logic [7:0] y);
    cyc(0, 0, 7'h00, 8'h00, 1, x, y);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 7'h00, 8'h00, 0, 8'h00, 8'h00);
    // R1 reset state
    rd(7'h02, "R1 status", 8'h00);
    rd(7'h03, "R1 dx", 8'h00);
    rd(7'h04, "R1 dy", 8'h00);
    rd(7'h0D, "R1 ctrl", 8'h00);
    rd(7'h05, "R2 unmapped", 8'h00);
    chk("R11 ready", {7'b0, smp_ready}, 8'h01);

    // table: R3 scaling, R4 saturation, R5 flag, R9 auto clear
    foreach (VEC[i]) begin
      wr(7'h0D, {7'b0, VEC[i][36]});
      wr(7'h02, 8'hA5);
      for (int k = 0; k < int'(VEC[i][35:33]); k++) smp(VEC[i][32:25], VEC[i][24:17]);
      rd(7'h02, "R5 flag", {VEC[i][0], 7'b0});
      rd(7'h03, "R3/R4 dx", VEC[i][16:9]);
      rd(7'h04, "R3/R4 dy", VEC[i][8:1]);
      rd(7'h02, "R9 flag after reads", 8'h00);
    end

    // R6 read clears only its own delta
    wr(7'h0D, 8'h01);
    smp(8'd5, 8'd6);
    rd(7'h03, "R6 dx value", 8'h05);
    rd(7'h02, "R9 flag kept while dy nonzero", 8'h80);
    rd(7'h03, "R6 dx cleared", 8'h00);
    rd(7'h04, "R6 dy untouched", 8'h06);
    rd(7'h02, "R9 flag cleared", 8'h00);

    // R8 sample in the same cycle as a clearing read
    smp(8'd5, 8'd6);
    cyc(1, 0, 7'h03, 8'h00, 1, 8'd3, 8'd0);
    chk("R8 read returns old", rd_val, 8'h05);
    rd(7'h03, "R8 dx after same-cycle add", 8'h03);
    rd(7'h04, "R8 dy", 8'h06);
    rd(7'h02, "R9 flag cleared", 8'h00);

    // R9 motion between the two reads keeps the flag
    smp(8'd2, 8'd2);
    rd(7'h03, "R9 dx", 8'h02);
    smp(8'd4, 8'd0);
    rd(7'h04, "R9 dy", 8'h02);
    rd(7'h02, "R9 flag kept by new motion", 8'h80);
    rd(7'h03, "R9 dx new", 8'h04);
    rd(7'h02, "R9 flag cleared", 8'h00);

    // R7 status write clears all and discards data
    smp(8'd7, 8'hF9);
    wr(7'h02, 8'hFF);
    rd(7'h02, "R7 status", 8'h00);
    rd(7'h03, "R7 dx", 8'h00);
    rd(7'h04, "R7 dy", 8'h00);

    // R8 sample in the same cycle as a status write
    smp(8'd7, 8'd7);
    cyc(0, 1, 7'h02, 8'h00, 1, 8'h01, 8'hFE);
    rd(7'h02, "R8 flag after write+sample", 8'h80);
    rd(7'h03, "R8 dx after write+sample", 8'h01);
    rd(7'h04, "R8 dy after write+sample", 8'hFE);

    // R10 power-down, R12 control readback
    wr(7'h0D, 8'h03);
    rd(7'h0D, "R12 ctrl", 8'h03);
    smp(8'd9, 8'd9);
    chk("R11 ready in power-down", {7'b0, smp_ready}, 8'h01);
    rd(7'h02, "R10 flag", 8'h00);
    rd(7'h03, "R10 dx", 8'h00);
    rd(7'h04, "R10 dy", 8'h00);
    wr(7'h0D, 8'hFF);
    rd(7'h0D, "R12 ctrl upper bits", 8'h03);
    wr(7'h0D, 8'h01);
    rd(7'h0D, "R12 ctrl", 8'h01);
    cyc(0, 0, 7'h00, 8'h00, 0, 8'h00, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule